// File: doc/BRIEF.md
# Directory Home Controller for Three-State Coherence

This block sits at the memory end of a two-level invalidation protocol with a parameter-set number of child caches. For every address of a small local store it holds the data word, the state it believes each child holds (invalid, shared or modified) and, per child, an optional pending wait on an outstanding downgrade. Children send upgrade requests on one channel per child and downgrade replies on a second channel per child. The block sends back one message per cycle on a single registered output: either an upgrade grant or a downgrade demand, with the destination child index.

Downgrade replies, whether demanded or voluntary, always win over requests. Requests are picked round robin. Before a request is granted, the block checks that no wait is open on that address and that every sibling is compatible with the requested state. A sibling that is not compatible is asked to step down, one per cycle. A grant carries the memory word only when the requester was recorded as holding nothing.

State encoding on all state fields: I = 0, S = 1, M = 2.

Top module: `msi_home_dir`

## Requirements
- R1: Two sibling states are compatible unless one is M (2) and the other is S (1) or M (2). A grant to M requires all other children at I. A grant to S requires all other children at I or S.
- R2: A request from child c for state y is granted only when no wait is open at its address for any child, c is recorded below y, and all siblings are compatible with y. The grant pulses `req_ready[c]` in that cycle and sets c's recorded state to y.
- R3: A grant appears on the output one cycle later with `msg_is_resp`=1, `msg_dest`=c, `msg_state`=y and the request address. `msg_has_data`=1 and `msg_data` holds the stored word only if c was recorded as I.
- R4: If a sibling conflicts and no wait is open at the address, the block drops the request without accepting it. It sends a downgrade (`msg_is_resp`=0) to the lowest-indexed conflicting sibling, targeting I for an M request and S for an S request, and opens a wait for that sibling.
- R5: A reply from child c with state y sets c's recorded state to y. It overwrites the stored word with the reply data only if c was recorded as M. It produces no output message.
- R6: While any wait is open at an address, requests to that address are neither granted nor cause a further downgrade. They stay unaccepted at the channel head.
- R7: A reply clears the wait of child c only if the awaited target is at or above the reply state. A partial step leaves the wait open.
- R8: When any reply is valid, the lowest-indexed one is accepted and no request is accepted in that cycle.
- R9: Among valid requests, the search starts at the child after the last one granted (child 0 after reset), wrapping around.
- R10: After reset no message is valid, every recorded state is I, no wait is open and every stored word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N | Upgrade request present, per child |
| req_addr | input | N*AW | Request address, per child |
| req_state | input | N*2 | Requested state, per child |
| req_ready | output | N | Request accepted this cycle |
| rsp_valid | input | N | Downgrade reply present, per child |
| rsp_addr | input | N*AW | Reply address, per child |
| rsp_state | input | N*2 | State the child stepped down to |
| rsp_data | input | N*DW | Data carried by the reply |
| rsp_ready | output | N | Reply accepted this cycle |
| msg_valid | output | 1 | Output message valid |
| msg_dest | output | CW | Destination child |
| msg_is_resp | output | 1 | 1 = upgrade grant, 0 = downgrade demand |
| msg_addr | output | AW | Message address |
| msg_state | output | 2 | Granted or demanded state |
| msg_has_data | output | 1 | `msg_data` is meaningful |
| msg_data | output | DW | Stored data word |

## Verification
The bench builds the block with four children, eight addresses and 16-bit words. With four children, one M request can meet two S holders at once, so sequential downgrades to the lowest-indexed sibling can be observed. Four children also let a simultaneous burst show the round-robin order wrapping past the last index. With eight addresses, random traffic revisits each address often, so stale-data faults from a wrong writeback condition show up in later grants that carry data.

// File: rtl/msi_home_pkg.sv
package msi_home_pkg;
  localparam logic [1:0] ST_I = 2'd0;
  localparam logic [1:0] ST_S = 2'd1;
  localparam logic [1:0] ST_M = 2'd2;

  // two sibling states may coexist
  function automatic logic st_fits(input logic [1:0] a, input logic [1:0] b);
    return !((a == ST_M && b != ST_I) || (b == ST_M && a != ST_I));
  endfunction

  // highest state a sibling may keep while another holds want
  function automatic logic [1:0] st_ceiling(input logic [1:0] want);
    return (want == ST_M) ? ST_I : ST_S;
  endfunction
endpackage

// File: rtl/msi_rr_pick.sv
module msi_rr_pick #(
  parameter int N  = 4,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vld,
  input  logic [CW-1:0] start,
  output logic [CW-1:0] pick,
  output logic          any
);
  int idx;
  always_comb begin
    pick = '0;
    any  = 1'b0;
    idx  = 0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = (int'(start) + k) % N;
      if (vld[idx]) begin
        pick = CW'(idx);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/msi_sib_check.sv
module msi_sib_check #(
  parameter int N  = 4,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][1:0] col,
  input  logic [N-1:0]      wcol,
  input  logic [CW-1:0]     who,
  input  logic [1:0]        want,
  output logic              ok,
  output logic [CW-1:0]     victim,
  output logic              victim_ok,
  output logic [1:0]        level
);
  import msi_home_pkg::*;
  logic [N-1:0] hit;

  assign level = st_ceiling(want);

  for (genvar i = 0; i < N; i++) begin : g_hit
    assign hit[i] = (CW'(i) != who) && (col[i] > level);
  end

  assign ok = ~|hit;

  always_comb begin
    victim    = '0;
    victim_ok = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i] && !wcol[i]) begin
        victim    = CW'(i);
        victim_ok = 1'b1;
      end
    end
  end
endmodule

// File: rtl/msi_home_dir.sv
module msi_home_dir #(
  parameter int N  = 4,
  parameter int AW = 3,
  parameter int DW = 16,
  parameter int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    req_valid,
  input  logic [N*AW-1:0] req_addr,
  input  logic [N*2-1:0]  req_state,
  output logic [N-1:0]    req_ready,
  input  logic [N-1:0]    rsp_valid,
  input  logic [N*AW-1:0] rsp_addr,
  input  logic [N*2-1:0]  rsp_state,
  input  logic [N*DW-1:0] rsp_data,
  output logic [N-1:0]    rsp_ready,
  output logic            msg_valid,
  output logic [CW-1:0]   msg_dest,
  output logic            msg_is_resp,
  output logic [AW-1:0]   msg_addr,
  output logic [1:0]      msg_state,
  output logic            msg_has_data,
  output logic [DW-1:0]   msg_data
);
  import msi_home_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [1:0]    dir_q [N][DEPTH];
  logic          wv_q  [N][DEPTH];
  logic [1:0]    wt_q  [N][DEPTH];
  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] rr_q;

  // reply selection: lowest index wins
  logic [CW-1:0] rc;
  logic          do_rsp;
  always_comb begin
    rc     = '0;
    do_rsp = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (rsp_valid[i]) begin
        rc     = CW'(i);
        do_rsp = 1'b1;
      end
    end
  end
  logic [AW-1:0] ra;
  logic [1:0]    ry;
  logic [DW-1:0] rd;
  assign ra = rsp_addr[rc*AW +: AW];
  assign ry = rsp_state[rc*2 +: 2];
  assign rd = rsp_data[rc*DW +: DW];

  // request selection: round robin
  logic [CW-1:0] qc;
  logic          q_any;
  msi_rr_pick #(.N(N), .CW(CW)) u_pick (
    .vld(req_valid), .start(rr_q), .pick(qc), .any(q_any)
  );
  logic [AW-1:0] qa;
  logic [1:0]    qy;
  assign qa = req_addr[qc*AW +: AW];
  assign qy = req_state[qc*2 +: 2];

  // column of directory state for the request address
  logic [N-1:0][1:0] col;
  logic [N-1:0]      wcol;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      col[i]  = dir_q[i][qa];
      wcol[i] = wv_q[i][qa];
    end
  end

  logic          sib_ok, vic_ok;
  logic [CW-1:0] vic;
  logic [1:0]    lvl;
  msi_sib_check #(.N(N), .CW(CW)) u_sib (
    .col(col), .wcol(wcol), .who(qc), .want(qy),
    .ok(sib_ok), .victim(vic), .victim_ok(vic_ok), .level(lvl)
  );

  logic any_wait, do_gnt, do_dg;
  logic [CW-1:0] rr_next;
  assign any_wait = |wcol;
  assign do_gnt   = !do_rsp && q_any && !any_wait && sib_ok && (col[qc] < qy);
  assign do_dg    = !do_rsp && q_any && !any_wait && !sib_ok && vic_ok;
  assign rr_next  = (int'(qc) == N - 1) ? '0 : qc + 1'b1;

  assign req_ready = do_gnt ? (N'(1) << qc) : '0;
  assign rsp_ready = do_rsp ? (N'(1) << rc) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        for (int a = 0; a < DEPTH; a++) begin
          dir_q[i][a] <= ST_I;
          wv_q[i][a]  <= 1'b0;
          wt_q[i][a]  <= ST_I;
        end
      end
      for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
      rr_q         <= '0;
      msg_valid    <= 1'b0;
      msg_dest     <= '0;
      msg_is_resp  <= 1'b0;
      msg_addr     <= '0;
      msg_state    <= ST_I;
      msg_has_data <= 1'b0;
      msg_data     <= '0;
    end else begin
      msg_valid <= 1'b0;
      if (do_rsp) begin
        if (dir_q[rc][ra] == ST_M) mem_q[ra] <= rd;
        dir_q[rc][ra] <= ry;
        if (wv_q[rc][ra] && (wt_q[rc][ra] >= ry)) wv_q[rc][ra] <= 1'b0;
      end else if (do_gnt) begin
        dir_q[qc][qa] <= qy;
        rr_q          <= rr_next;
        msg_valid     <= 1'b1;
        msg_dest      <= qc;
        msg_is_resp   <= 1'b1;
        msg_addr      <= qa;
        msg_state     <= qy;
        msg_has_data  <= (col[qc] == ST_I);
        msg_data      <= mem_q[qa];
      end else if (do_dg) begin
        wv_q[vic][qa] <= 1'b1;
        wt_q[vic][qa] <= lvl;
        msg_valid     <= 1'b1;
        msg_dest      <= vic;
        msg_is_resp   <= 1'b0;
        msg_addr      <= qa;
        msg_state     <= lvl;
        msg_has_data  <= 1'b0;
        msg_data      <= '0;
      end
    end
  end

  AST_REPLY_FIRST: assert property (@(posedge clk) disable iff (rst)
    (|rsp_valid) |-> (req_ready == '0)); // R8

  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_ready, rsp_ready})); // R2

  AST_GRANT_SENT: assert property (@(posedge clk) disable iff (rst)
    (|req_ready) |=> (msg_valid && msg_is_resp)); // R3

  AST_DEMAND_WAITS: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_is_resp) |-> wv_q[msg_dest][msg_addr]); // R4

  for (genvar i = 0; i < N; i++) begin : g_fit
    AST_SIB_FIT: assert property (@(posedge clk) disable iff (rst)
      (msg_valid && msg_is_resp && msg_dest != CW'(i)) |->
        st_fits(dir_q[i][msg_addr], msg_state)); // R1
  end
endmodule

// File: tb/sim_msi_home_dir.sv
module sim_msi_home_dir;
  localparam int N = 4;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam int CW = 2;
  localparam int DEPTH = 1 << AW;
  localparam time TCLK = 10;
  localparam logic [1:0] SI = 2'd0, SS = 2'd1, SM = 2'd2;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] req_valid, req_ready, rsp_valid, rsp_ready;
  logic [N*AW-1:0] req_addr, rsp_addr;
  logic [N*2-1:0] req_state, rsp_state;
  logic [N*DW-1:0] rsp_data;
  logic msg_valid, msg_is_resp, msg_has_data;
  logic [CW-1:0] msg_dest;
  logic [AW-1:0] msg_addr;
  logic [1:0] msg_state;
  logic [DW-1:0] msg_data;

  always #(TCLK/2) clk = ~clk;

  msi_home_dir #(.N(N), .AW(AW), .DW(DW), .CW(CW)) u0 (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_state(req_state), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_state(rsp_state), .rsp_data(rsp_data),
    .rsp_ready(rsp_ready), .msg_valid(msg_valid), .msg_dest(msg_dest), .msg_is_resp(msg_is_resp),
    .msg_addr(msg_addr), .msg_state(msg_state), .msg_has_data(msg_has_data), .msg_data(msg_data)
  );

  int checks = 0, errors = 0;
  logic [1:0]    mdir [N][DEPTH];
  logic [DW-1:0] mmem [DEPTH];
  int rrn = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] msg_pack();
    return {55'd0, msg_valid, msg_dest, msg_is_resp, msg_state, msg_addr};
  endfunction

  function automatic logic [63:0] exp_pack(int d, bit resp, logic [1:0] s, int a);
    return {55'd0, 1'b1, CW'(d), resp, s, AW'(a)};
  endfunction

  function automatic int victim_of(int c, int a, logic [1:0] y);
    logic [1:0] lim;
    lim = (y == SM) ? SI : SS;
    for (int i = 0; i < N; i++)
      if (i != c && mdir[i][a] > lim) return i;
    return -1;
  endfunction

  task automatic idle();
    req_valid = '0; req_addr = '0; req_state = '0;
    rsp_valid = '0; rsp_addr = '0; rsp_state = '0; rsp_data = '0;
  endtask

  // full transaction for one request, answering demands after hold cycles
  task automatic serve(int c, int a, logic [1:0] y, int hold_in, bit partial);
    bit done, pend, second;
    int pi, hold, v;
    logic [1:0] py, lvl;
    logic [DW-1:0] pd;
    done = 0; pend = 0; second = 0; pi = 0; hold = 0; py = SI; pd = '0;
    for (int t = 0; t < 24 && !done; t++) begin
      @(negedge clk);
      idle();
      req_valid[c] = 1'b1; req_addr[c*AW +: AW] = AW'(a); req_state[c*2 +: 2] = y;
      if (pend && hold == 0) begin
        rsp_valid[pi] = 1'b1; rsp_addr[pi*AW +: AW] = AW'(a);
        rsp_state[pi*2 +: 2] = py; rsp_data[pi*DW +: DW] = pd;
      end
      #1;
      if (pend && hold > 0) begin
        hold--;
        chk(req_ready == '0 && rsp_ready == '0, second ? "R6 blocked by wait" : "R7 wait kept",
            {60'd0, req_ready}, 64'd0);
        @(posedge clk); #1;
        chk(!msg_valid, "R6 no message while waiting", msg_pack(), 64'd0);
      end else if (pend) begin
        chk(rsp_ready == (N'(1) << pi) && req_ready == '0, "R8 reply first",
            {56'd0, rsp_ready, req_ready}, {56'd0, N'(1) << pi, 4'd0});
        if (mdir[pi][a] == SM) mmem[a] = pd;
        mdir[pi][a] = py;
        pd = DW'($urandom);
        if (second) begin second = 0; py = SI; hold = 1; end
        else pend = 0;
        @(posedge clk); #1;
        chk(!msg_valid, "R5 reply silent", msg_pack(), 64'd0);
      end else begin
        v = victim_of(c, a, y);
        if (v >= 0) begin
          lvl = (y == SM) ? SI : SS;
          chk(req_ready == '0, "R4 request held", {60'd0, req_ready}, 64'd0);
          @(posedge clk); #1;
          chk(msg_pack() == exp_pack(v, 0, lvl, a), "R4 downgrade demand", msg_pack(), exp_pack(v, 0, lvl, a));
          pend = 1; pi = v; hold = hold_in; pd = DW'($urandom);
          if (partial && lvl == SI && mdir[v][a] == SM) begin second = 1; py = SS; end
          else begin second = 0; py = lvl; end
        end else begin
          bit hd;
          logic [DW-1:0] ed;
          hd = (mdir[c][a] == SI); ed = mmem[a];
          chk(req_ready == (N'(1) << c), "R2 grant accept", {60'd0, req_ready}, {60'd0, N'(1) << c});
          mdir[c][a] = y; rrn = (c + 1) % N;
          @(posedge clk); #1;
          chk(msg_pack() == exp_pack(c, 1, y, a), "R3 grant message", msg_pack(), exp_pack(c, 1, y, a));
          chk(msg_has_data == hd && (!hd || msg_data == ed), "R3 grant data",
              {47'd0, msg_has_data, msg_data}, {47'd0, hd, ed});
          done = 1;
        end
      end
    end
    chk(done, "R2 request completes", 64'(done), 64'd1);
    @(negedge clk); idle();
  endtask

  task automatic vol(int c, int a, logic [1:0] y);
    logic [DW-1:0] d;
    d = DW'($urandom);
    @(negedge clk);
    idle();
    rsp_valid[c] = 1'b1; rsp_addr[c*AW +: AW] = AW'(a); rsp_state[c*2 +: 2] = y; rsp_data[c*DW +: DW] = d;
    #1;
    chk(rsp_ready == (N'(1) << c), "R5 voluntary accept", {60'd0, rsp_ready}, {60'd0, N'(1) << c});
    if (mdir[c][a] == SM) mmem[a] = d;
    mdir[c][a] = y;
    @(posedge clk); #1;
    chk(!msg_valid, "R5 voluntary silent", msg_pack(), 64'd0);
    @(negedge clk); idle();
  endtask

  // simultaneous compatible S requests, order follows the round robin
  task automatic rr_burst(logic [N-1:0] mask, int a);
    logic [N-1:0] left;
    int w;
    left = mask;
    for (int t = 0; t < 2 * N && left != '0; t++) begin
      @(negedge clk);
      idle();
      for (int k = 0; k < N; k++)
        if (left[k]) begin
          req_valid[k] = 1'b1; req_addr[k*AW +: AW] = AW'(a); req_state[k*2 +: 2] = SS;
        end
      #1;
      w = -1;
      for (int k = N - 1; k >= 0; k--)
        if (left[(rrn + k) % N]) w = (rrn + k) % N;
      chk(req_ready == (N'(1) << w), "R9 round robin pick", {60'd0, req_ready}, {60'd0, N'(1) << w});
      mdir[w][a] = SS; rrn = (w + 1) % N;
      @(posedge clk); #1;
      chk(msg_pack() == exp_pack(w, 1, SS, a), "R9 grant order", msg_pack(), exp_pack(w, 1, SS, a));
      left[w] = 1'b0;
    end
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c, a, r;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) for (int j = 0; j < DEPTH; j++) mdir[i][j] = SI;
    for (int j = 0; j < DEPTH; j++) mmem[j] = '0;
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(!msg_valid && req_ready == '0 && rsp_ready == '0, "R10 reset idle", msg_pack(), 64'd0);

    serve(0, 0, SS, 0, 0);          // R10 zero data, R3
    rr_burst(4'b1111, 5);           // R9 starts after child 0
    serve(2, 4, SS, 0, 0);
    rr_burst(4'b1011, 6);           // R9 wrap from child 3
    serve(2, 3, SM, 0, 0);
    serve(1, 3, SS, 2, 0);          // R6 hold with open wait, R1 S+M conflict
    serve(3, 3, SM, 0, 0);          // R4 two S holders stepped down in turn
    serve(0, 2, SM, 0, 0);
    serve(1, 2, SM, 1, 1);          // R7 partial step keeps wait
    vol(1, 2, SI);                  // R5 writeback from M
    serve(2, 2, SS, 0, 0);          // R3 data reflects writeback
    serve(3, 2, SS, 0, 0);          // R1 S with S compatible
    vol(3, 2, SI);                  // R5 S reply data ignored
    serve(0, 2, SS, 0, 0);

    for (int it = 0; it < 400; it++) begin
      c = $urandom % N; a = $urandom % DEPTH; r = $urandom % 4;
      if (mdir[c][a] != SM && r != 0) begin
        if (mdir[c][a] == SI && r == 1) serve(c, a, SS, $urandom % 3, 0);
        else serve(c, a, SM, $urandom % 3, $urandom % 2);
      end else if (mdir[c][a] != SI) begin
        vol(c, a, (mdir[c][a] == SM && r[0]) ? SS : SI);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule